// File: doc/BRIEF.md
# SMRAM Control and Access Router

This block keeps the control byte for system-management RAM and decides, for the access being presented, whether it is served from DRAM or forwarded to PCI. Software writes the byte through a simple write port. Only the open, closed, lock and enable fields are stored. The top bit always reads zero and the low three bits always read back the fixed base segment.

The lock field is a one-way latch. Once it is set, the open field stays clear and lock cannot be cleared by any write. A soft reset clears the other fields and leaves lock alone. Only the power-on reset input clears lock.

The route output is combinational. It is computed from the stored fields, the CPU's system-management-mode indicator and an input that says whether the access is a code fetch or a data reference. Setting open and closed together while unlocked is an illegal setting. The block flags it and routes everything to PCI.

Top module: `smram_router`

## Requirements
- R1: After power-on reset (`porRstN` low) the control byte reads 0x02.
- R2: A write stores data bits 6 (open), 5 (closed), 4 (lock) and 3 (enable). Bit 7 always reads 0 and bits 2:0 always read the base segment 3'b010.
- R3: Once lock (bit 4) is stored, no write can clear it, and open (bit 6) is stored as 0 on the write that sets lock and on every write after it.
- R4: A soft reset clears open, closed and enable and keeps lock. Soft reset wins over a write in the same cycle, and only power-on reset clears lock.
- R5: With enable clear, both code and data accesses go to PCI (`routeDram`=0).
- R6: With enable set, open clear and SMM mode clear, both access types go to PCI.
- R7: With enable set, SMM mode set and closed clear, both access types go to DRAM (`routeDram`=1).
- R8: With enable set, lock clear, open set and closed clear, both access types go to DRAM whether or not SMM mode is set.
- R9: With enable set and closed set, an access in SMM mode goes to DRAM if it is code (`accData`=0) and to PCI if it is data (`accData`=1). When locked and outside SMM mode, both go to PCI.
- R10: `illegalCfg` is 1 exactly when open and closed are both set and lock is clear. While it is 1, both access types go to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous active-low power-on reset; the only way to clear lock |
| softRst | input | 1 | Synchronous soft reset; clears open, closed and enable |
| wrEn | input | 1 | Write strobe for the control byte |
| wrData | input | 8 | Write data |
| smmMode | input | 1 | CPU is in system-management mode |
| accData | input | 1 | Access type: 1 = data reference, 0 = code fetch |
| ctrlValue | output | 8 | Control byte read value |
| routeDram | output | 1 | 1 = serve the access from DRAM, 0 = forward it to PCI |
| illegalCfg | output | 1 | Open and closed are set together while unlocked |

## Verification
The bench builds the block with the default base segment of 3'b010. With that value, the readback of every write also checks that the fixed low bits and the masked top bit stay in place.

Unlocked field combinations are covered by a vector table that crosses each setting with SMM mode and both access types. The illegal open-plus-closed setting is included, with enable set and with enable clear. Directed sequences then set lock with open requested and try to undo it by writes and by soft reset. A soft reset and a write are also raised in the same cycle, to check that soft reset takes priority. Finally, power-on reset releases the lock and open becomes writable again.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int OPEN_BIT   = 6;
  localparam int CLOSED_BIT = 5;
  localparam int LOCK_BIT   = 4;
  localparam int ENABLE_BIT = 3;

  typedef struct packed {
    logic load;     // capture a new control byte
    logic softClr;  // soft reset: clear all but lock
  } ctlStrobe_t;

  typedef struct packed {
    logic open;
    logic closed;
    logic lock;
    logic enable;
  } smramFields_t;
endpackage

// File: rtl/smram_reg_path.sv
module smram_reg_path
  import smram_pkg::*;
#(
  parameter logic [2:0] BASE_SEG = 3'b010
) (
  input  logic         clk,
  input  logic         porRstN,
  input  ctlStrobe_t   strobe,
  input  logic [7:0]   wrData,
  output smramFields_t fields,
  output logic [7:0]   ctrlValue
);
  smramFields_t fieldsQ;
  smramFields_t fieldsNext;
  logic         lockNext;

  // Lock is sticky; once it is (or becomes) set, open cannot be stored.
  always_comb begin
    lockNext          = fieldsQ.lock | wrData[LOCK_BIT];
    fieldsNext.lock   = lockNext;
    fieldsNext.open   = wrData[OPEN_BIT] & ~lockNext;
    fieldsNext.closed = wrData[CLOSED_BIT];
    fieldsNext.enable = wrData[ENABLE_BIT];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      fieldsQ <= '0;
    end else if (strobe.softClr) begin
      fieldsQ.open   <= 1'b0;
      fieldsQ.closed <= 1'b0;
      fieldsQ.enable <= 1'b0;
    end else if (strobe.load) begin
      fieldsQ <= fieldsNext;
    end
  end

  assign fields    = fieldsQ;
  assign ctrlValue = {1'b0, fieldsQ.open, fieldsQ.closed, fieldsQ.lock,
                      fieldsQ.enable, BASE_SEG};
endmodule

// File: rtl/smram_route_ctl.sv
module smram_route_ctl
  import smram_pkg::*;
(
  input  logic         wrEn,
  input  logic         softRst,
  input  smramFields_t fields,
  input  logic         smmMode,
  input  logic         accData,
  output ctlStrobe_t   strobe,
  output logic         routeDram,
  output logic         illegalCfg
);
  logic visible;
  logic codeDram;
  logic dataDram;

  always_comb begin
    strobe.softClr = softRst;
    strobe.load    = wrEn & ~softRst;
  end

  always_comb begin
    illegalCfg = fields.open & fields.closed & ~fields.lock;
    // open is always clear while locked, so open | smm covers every row
    visible    = fields.open | smmMode;
    codeDram   = fields.enable & ~illegalCfg & visible;
    dataDram   = codeDram & ~fields.closed;
    routeDram  = accData ? dataDram : codeDram;
  end
endmodule

// File: rtl/smram_router.sv
module smram_router
  import smram_pkg::*;
#(
  parameter logic [2:0] BASE_SEG = 3'b010
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       softRst,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       smmMode,
  input  logic       accData,
  output logic [7:0] ctrlValue,
  output logic       routeDram,
  output logic       illegalCfg
);
  ctlStrobe_t   strobe;
  smramFields_t fields;

  smram_route_ctl uCtl (
    .wrEn       (wrEn),
    .softRst    (softRst),
    .fields     (fields),
    .smmMode    (smmMode),
    .accData    (accData),
    .strobe     (strobe),
    .routeDram  (routeDram),
    .illegalCfg (illegalCfg)
  );

  smram_reg_path #(.BASE_SEG(BASE_SEG)) uPath (
    .clk       (clk),
    .porRstN   (porRstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .fields    (fields),
    .ctrlValue (ctrlValue)
  );
endmodule

// File: rtl/smram_router_chk.sv
module smram_router_chk (
  input logic       clk,
  input logic       porRstN,
  input logic       softRst,
  input logic       accData,
  input logic [7:0] ctrlValue,
  input logic       routeDram,
  input logic       illegalCfg
);
  // R2
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!porRstN)
    ctrlValue[7] == 1'b0 && ctrlValue[2:0] == 3'b010);
  // R3
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!porRstN)
    ctrlValue[4] |=> ctrlValue[4]);
  // R3
  a_r3_lock_no_open: assert property (@(posedge clk) disable iff (!porRstN)
    ctrlValue[4] |-> !ctrlValue[6]);
  // R4
  a_r4_soft_clear: assert property (@(posedge clk) disable iff (!porRstN)
    softRst |=> (ctrlValue[6:3] == {2'b00, $past(ctrlValue[4]), 1'b0}));
  // R5
  a_r5_disabled_pci: assert property (@(posedge clk) disable iff (!porRstN)
    !ctrlValue[3] |-> !routeDram);
  // R9
  a_r9_closed_data_pci: assert property (@(posedge clk) disable iff (!porRstN)
    (ctrlValue[5] && accData) |-> !routeDram);
  // R10
  a_r10_illegal_pci: assert property (@(posedge clk) disable iff (!porRstN)
    illegalCfg |-> !routeDram);
endmodule

bind smram_router smram_router_chk uChk (
  .clk        (clk),
  .porRstN    (porRstN),
  .softRst    (softRst),
  .accData    (accData),
  .ctrlValue  (ctrlValue),
  .routeDram  (routeDram),
  .illegalCfg (illegalCfg)
);

// File: tb/tb_smram_router.sv
module tb_smram_router;
  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       softRst = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       smmMode = 1'b0;
  logic       accData = 1'b0;
  logic [7:0] ctrlValue;
  logic       routeDram;
  logic       illegalCfg;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  smram_router dut (
    .clk(clk), .porRstN(porRstN), .softRst(softRst), .wrEn(wrEn),
    .wrData(wrData), .smmMode(smmMode), .accData(accData),
    .ctrlValue(ctrlValue), .routeDram(routeDram), .illegalCfg(illegalCfg)
  );

  typedef struct packed {
    logic [7:0] wr;
    logic       smm;
    logic       code;
    logic       data;
    logic       ill;
    logic [7:0] rb;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02},  // R5
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02},  // R5
    '{8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0A},  // R6
    '{8'h08, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0A},  // R7
    '{8'h28, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2A},  // R9
    '{8'h28, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2A},  // R6
    '{8'h48, 1'b0, 1'b1, 1'b1, 1'b0, 8'h4A},  // R8
    '{8'h48, 1'b1, 1'b1, 1'b1, 1'b0, 8'h4A},  // R8
    '{8'h68, 1'b0, 1'b0, 1'b0, 1'b1, 8'h6A},  // R10
    '{8'h60, 1'b1, 1'b0, 1'b0, 1'b1, 8'h62},  // R10
    '{8'hA7, 1'b1, 1'b0, 1'b0, 1'b0, 8'h22},  // R2
    '{8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 8'h42}   // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doSoft();
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
  endtask

  task automatic checkRoute(input string req, input logic smm,
                            input logic expCode, input logic expData,
                            input logic expIll);
    smmMode = smm;
    accData = 1'b0;
    #1;
    check({req, " code route"}, {7'd0, routeDram}, {7'd0, expCode});
    check({req, " illegal flag"}, {7'd0, illegalCfg}, {7'd0, expIll});
    accData = 1'b1;
    #1;
    check({req, " data route"}, {7'd0, routeDram}, {7'd0, expData});
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", ctrlValue, 8'h02);
    porRstN = 1'b1;
    @(negedge clk);
    check("R1 value after release", ctrlValue, 8'h02);
    checkRoute("R5 after reset", 1'b1, 1'b0, 1'b0, 1'b0);

    // Table walk: R2 readback, routing per R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].wr);
      check($sformatf("R2 vector %0d readback", i), ctrlValue, VECS[i].rb);
      checkRoute($sformatf("R6/R7/R8/R9/R10 vector %0d", i), VECS[i].smm,
                 VECS[i].code, VECS[i].data, VECS[i].ill);
    end

    // R4: soft reset from an enabled, open setting
    doWrite(8'h48);
    doSoft();
    check("R4 soft reset unlocked", ctrlValue, 8'h02);

    // R3: lock with open requested, open forced clear
    doWrite(8'h58);
    check("R3 lock set drops open", ctrlValue, 8'h1A);
    checkRoute("R6 locked no smm", 1'b0, 1'b0, 1'b0, 1'b0);
    checkRoute("R7 locked smm", 1'b1, 1'b1, 1'b1, 1'b0);
    doWrite(8'h08);
    check("R3 lock sticky on write", ctrlValue, 8'h1A);
    doWrite(8'h68);
    check("R3 open blocked while locked", ctrlValue, 8'h3A);
    checkRoute("R9 locked closed smm", 1'b1, 1'b1, 1'b0, 1'b0);
    checkRoute("R9 locked closed no smm", 1'b0, 1'b0, 1'b0, 1'b0);
    doWrite(8'h00);
    check("R3 lock kept, enable cleared", ctrlValue, 8'h12);
    checkRoute("R5 locked disabled", 1'b1, 1'b0, 1'b0, 1'b0);
    doWrite(8'h28);
    doSoft();
    check("R4 soft reset keeps lock", ctrlValue, 8'h12);

    // R4: soft reset and write in the same cycle, soft wins
    @(negedge clk);
    softRst = 1'b1;
    wrEn = 1'b1;
    wrData = 8'h28;
    @(negedge clk);
    softRst = 1'b0;
    wrEn = 1'b0;
    check("R4 soft reset beats write", ctrlValue, 8'h12);

    // R1/R4: only power-on reset clears lock
    @(negedge clk);
    porRstN = 1'b0;
    #2;
    check("R1 power-on reset clears lock", ctrlValue, 8'h02);
    @(negedge clk);
    porRstN = 1'b1;
    doWrite(8'h48);
    check("R4 open writable after power-on", ctrlValue, 8'h4A);
    checkRoute("R8 after power-on", 1'b0, 1'b1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule